// File: doc/BRIEF.md
# Synchronous Bus Clock Stop Gate

This block sits between a set of already-divided bus clocks and the pins that drive them off the die. It accepts a slow bus-rate source (nominally 33 MHz) and a fast source (nominally 66 MHz) as ordinary signals oversampled by a fast system clock. It produces three kinds of gated outputs. The first is a bank of stoppable bus clocks. The second is a shared group whose rate is chosen by an active-low strap. The third is one dedicated free-running output. An asynchronous active-low stop request passes through a synchroniser. The block then decides, output by output, whether that output is eligible to stop.

Each output has a gate that only moves while its own source is low. Stopping therefore waits for the end of a high phase, and restarting waits for the next low phase. Every high pulse seen at an output has full width, and an output that is stopped rests at logic low. Each output also has an enable bit that holds it low whenever the bit is clear. Each stoppable bus output has a free-run bit that makes it ignore the stop request.

Top module: `clkstop_bank`

## Requirements
- R1: While the synchronised `stop_n_i` is 0, every bus output whose free-run bit is 0 holds low. While `stop_n_i` is 1, enabled bus outputs run.
- R2: The free-running output `fr_clk_o` (enable bit `out_en_i[N_BUS+N_GRP]`) never responds to `stop_n_i`.
- R3: Group outputs obey the stop request only when they run at the slow rate (`grp_slow_n_i` = 1). At the fast rate they keep running while the stop request is active.
- R4: `grp_slow_n_i` = 0 makes the group follow `src_fast_i`, and `grp_slow_n_i` = 1 makes it follow `src_bus_i`.
- R5: A bus output whose bit in `free_run_i` is 1 ignores the stop request.
- R6: A cleared enable bit holds its output low whatever the stop request. Enable layout: bits [N_BUS-1:0] are the bus outputs, bits [N_BUS+N_GRP-1:N_BUS] are the group, and the top bit is the free-running output.
- R7: Gates change state only while the source is low. Every output high pulse therefore lasts exactly one full source high phase, with no runt pulses on stop, restart or enable change.
- R8: All outputs are low during reset, and stopped outputs rest at logic low.
- R9: A running output equals its source as sampled one `clk` cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sources |
| rst | input | 1 | Synchronous active-high reset |
| src_bus_i | input | 1 | Slow bus-rate source clock |
| src_fast_i | input | 1 | Fast source clock for the group |
| stop_n_i | input | 1 | Asynchronous active-low stop request |
| grp_slow_n_i | input | 1 | Group rate strap: 0 fast, 1 slow |
| out_en_i | input | N_BUS+N_GRP+1 | Per-output enable bits |
| free_run_i | input | N_BUS | Per-bus-output free-run bits |
| bus_clk_o | output | N_BUS | Gated bus clocks |
| grp_clk_o | output | N_GRP | Gated group clocks |
| fr_clk_o | output | 1 | Free-running clock output |

## Verification
The hardest case to reach from the ports is a stop request or a release that arrives at an arbitrary phase of the source clock, and especially one that arrives just before a falling or rising source edge, where a careless gate would cut a pulse short. The bench sweeps the moment it asserts and releases the stop request across all eight system-clock phases of one source period. It measures the length of every high pulse on a stoppable output and on the free-running output. It then confirms that the outputs stop and restart only on whole pulses.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int unsigned DEF_BUS    = 6;
  localparam int unsigned DEF_GRP    = 3;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic {RATE_FAST = 1'b0, RATE_SLOW = 1'b1} grp_rate_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n_i,
  output logic req_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_n_i};
  end

  assign req_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/cs_gate_cell.sv
module cs_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic want_i,
  output logic clk_o
);
  logic gate_q;
  logic out_q;

  // gate only moves during the low phase of its source
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!src_i) gate_q <= want_i;
      out_q <= src_i & gate_q;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/clkstop_bank.sv
module clkstop_bank
  import clkstop_pkg::*;
#(
  parameter int unsigned N_BUS  = DEF_BUS,
  parameter int unsigned N_GRP  = DEF_GRP,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     src_bus_i,
  input  logic                     src_fast_i,
  input  logic                     stop_n_i,
  input  logic                     grp_slow_n_i,
  input  logic [N_BUS+N_GRP:0]     out_en_i,
  input  logic [N_BUS-1:0]         free_run_i,
  output logic [N_BUS-1:0]         bus_clk_o,
  output logic [N_GRP-1:0]         grp_clk_o,
  output logic                     fr_clk_o
);
  localparam int unsigned GRP_LO = N_BUS;
  localparam int unsigned FR_BIT = N_BUS + N_GRP;

  logic      stop_req;
  grp_rate_e grp_rate;
  logic      grp_src;
  logic      grp_may_stop;

  cs_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_n_i (stop_n_i),
    .req_o     (stop_req)
  );

  assign grp_rate     = grp_rate_e'(grp_slow_n_i);
  assign grp_src      = (grp_rate == RATE_SLOW) ? src_bus_i : src_fast_i;
  assign grp_may_stop = (grp_rate == RATE_SLOW);

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    logic want;
    assign want = out_en_i[b] & (free_run_i[b] | ~stop_req);
    cs_gate_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .src_i  (src_bus_i),
      .want_i (want),
      .clk_o  (bus_clk_o[b])
    );
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic want;
    assign want = out_en_i[GRP_LO+g] & ~(grp_may_stop & stop_req);
    cs_gate_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .src_i  (grp_src),
      .want_i (want),
      .clk_o  (grp_clk_o[g])
    );
  end

  cs_gate_cell u_fr_cell (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_bus_i),
    .want_i (out_en_i[FR_BIT]),
    .clk_o  (fr_clk_o)
  );
endmodule

// File: rtl/clkstop_bank_chk.sv
module clkstop_bank_chk #(
  parameter int unsigned N_BUS = 6,
  parameter int unsigned N_GRP = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             src_bus_i,
  input logic             src_fast_i,
  input logic             grp_slow_n_i,
  input logic [N_BUS-1:0] bus_clk_o,
  input logic [N_GRP-1:0] grp_clk_o,
  input logic             fr_clk_o
);
  for (genvar i = 0; i < N_BUS; i++) begin : g_b
    AST_BUS_REST_LOW: assert property (@(posedge clk) disable iff (rst)
      bus_clk_o[i] |-> $past(src_bus_i));                     // R8
    AST_BUS_FULL_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_clk_o[i]) |-> !$past(src_bus_i, 2));          // R7
    AST_BUS_FULL_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_clk_o[i]) |-> !$past(src_bus_i));             // R7
  end

  for (genvar j = 0; j < N_GRP; j++) begin : g_g
    AST_GRP_SRC_SEL: assert property (@(posedge clk) disable iff (rst)
      grp_clk_o[j] |-> $past(grp_slow_n_i ? src_bus_i : src_fast_i)); // R4
  end

  AST_FR_REST_LOW: assert property (@(posedge clk) disable iff (rst)
    fr_clk_o |-> $past(src_bus_i));                           // R8
  AST_FR_FULL_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fr_clk_o) |-> !$past(src_bus_i, 2));                // R7
endmodule

bind clkstop_bank clkstop_bank_chk #(.N_BUS(N_BUS), .N_GRP(N_GRP)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_bus_i    (src_bus_i),
  .src_fast_i   (src_fast_i),
  .grp_slow_n_i (grp_slow_n_i),
  .bus_clk_o    (bus_clk_o),
  .grp_clk_o    (grp_clk_o),
  .fr_clk_o     (fr_clk_o)
);

// File: tb/clkstop_bank_tb.sv
`timescale 1ns/1ps
module clkstop_bank_tb;
  localparam int NB = 6;
  localparam int NG = 3;
  localparam int NO = NB + NG + 1;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]    cnt = '0;
  logic          src33, src66;
  logic          stop_n = 1'b1, sel_n = 1'b1;
  logic [NO-1:0] en = '1;
  logic [NB-1:0] fr = '0;
  logic [NB-1:0] bus_o;
  logic [NG-1:0] grp_o;
  logic          fr_o;

  assign src33 = cnt[2];
  assign src66 = cnt[1];

  clkstop_bank #(.N_BUS(NB), .N_GRP(NG)) u_dut (
    .clk(clk), .rst(rst), .src_bus_i(src33), .src_fast_i(src66),
    .stop_n_i(stop_n), .grp_slow_n_i(sel_n), .out_en_i(en),
    .free_run_i(fr), .bus_clk_o(bus_o), .grp_clk_o(grp_o), .fr_clk_o(fr_o)
  );

  // {stop_n, sel_n, en[9:0], free[5:0], run_mask[9:0]}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b1, 10'h3FF, 6'h00, 10'h3FF},
    {1'b0, 1'b1, 10'h3FF, 6'h00, 10'h200},
    {1'b0, 1'b0, 10'h3FF, 6'h00, 10'h3C0},
    {1'b0, 1'b1, 10'h3FF, 6'h29, 10'h229},
    {1'b1, 1'b0, 10'h173, 6'h00, 10'h173},
    {1'b0, 1'b0, 10'h2BF, 6'h03, 10'h283},
    {1'b1, 1'b1, 10'h3FF, 6'h3F, 10'h3FF},
    {1'b0, 1'b1, 10'h000, 6'h3F, 10'h000}
  };
  localparam string TAG [NV] = '{"R9", "R1", "R3 R4", "R5", "R6 R4",
                                 "R6 R5", "R5 idle", "R6 R8"};

  int checks = 0, fails = 0;
  bit mon_on = 0;
  logic [NO-1:0] exp_mask = '0;
  int mism = 0;
  logic [NO-1:0] bad_act, bad_exp;
  int len_b0 = 0, len_fr = 0, runts = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // sample outputs, then advance the sources, all on the falling edge
  always @(negedge clk) begin
    logic [NO-1:0] act, exp;
    logic gsrc;
    gsrc = sel_n ? cnt[2] : cnt[1];
    act  = {fr_o, grp_o, bus_o};
    for (int i = 0; i < NO; i++) begin
      logic s;
      s = (i >= NB && i < NB + NG) ? gsrc : cnt[2];
      exp[i] = exp_mask[i] & s;
    end
    if (mon_on && act !== exp) begin
      mism++;
      bad_act = act;
      bad_exp = exp;
    end
    if (!rst) begin
      if (bus_o[0]) len_b0++;
      else if (len_b0 != 0) begin if (len_b0 != 4) runts++; len_b0 = 0; end
      if (fr_o) len_fr++;
      else if (len_fr != 0) begin if (len_fr != 4) runts++; len_fr = 0; end
    end
    cnt <= cnt + 3'd1;
  end

  task automatic window(string req, logic [NO-1:0] mask);
    exp_mask = mask;
    mism = 0;
    mon_on = 1;
    repeat (16) @(negedge clk);
    mon_on = 0;
    check(mism == 0, req, "output pattern", 32'(bad_act), 32'(bad_exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: outputs low in reset
    check({fr_o, grp_o, bus_o} == '0, "R8", "reset outputs", 32'({fr_o, grp_o, bus_o}), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (24) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] w;
      w = VEC[v];
      stop_n = w[27];
      sel_n  = w[26];
      en     = w[25:16];
      fr     = w[15:10];
      repeat (32) @(negedge clk);
      window(TAG[v], w[9:0]);
    end

    // R7/R1: stop and release at each phase of the source period
    for (int ph = 0; ph < 8; ph++) begin
      int r0;
      stop_n = 1'b1; sel_n = 1'b1; en = '1; fr = '0;
      repeat (32) @(negedge clk);
      while (cnt != 3'(ph)) @(negedge clk);
      r0 = runts;
      stop_n = 1'b0;
      repeat (24 + ph) @(negedge clk);
      window("R1", 10'h200);
      stop_n = 1'b1;
      repeat (24) @(negedge clk);
      window("R9", 10'h3FF);
      check(runts == r0, "R7", "runt pulses", 32'(runts - r0), 0);
    end

    // R7: enable toggles mid-phase give no runts
    begin
      int r0;
      r0 = runts;
      for (int k = 0; k < 8; k++) begin
        repeat (3 + k) @(negedge clk);
        en[0] = ~en[0];
        en[NO-1] = ~en[NO-1];
      end
      repeat (16) @(negedge clk);
      check(runts == r0, "R7", "runts on enable change", 32'(runts - r0), 0);
    end

    // R2: free output unaffected by stop with all else stopped
    en = '1; fr = '0; sel_n = 1'b1; stop_n = 1'b0;
    repeat (32) @(negedge clk);
    window("R2", 10'h200);
    finish_run();
  end
endmodule